// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block keeps the eight service-request flags of a CAN controller next to an eight-bit enable register, and combines them into one active-low interrupt line. Single-cycle event pulses from the transmit buffers, receive buffers, error logic and wake logic raise the flags. A host port can read either register at any time. It applies a masked bit-modify to either register. A plain write is a bit-modify whose mask is 0xFF.

The block also reports the highest-priority pending enabled source as a three-bit code. It drives two active-low buffer-full pins, one per receive buffer, and these pins do not depend on the enable register. For each source, a hold input carries the condition that raised its flag, for example unread data in a receive buffer. While that hold input is high, the flag cannot be cleared.

Top module: `can_irq_flags`

## Requirements
- R1: After reset, both registers read 0x00, `irq_n` is 1, `irq_code` is 000 and `rxfull_n` is 2'b11.
- R2: The flag bits are mapped as follows: bit0 RX buffer 0, bit1 RX buffer 1, bit2 TX0, bit3 TX1, bit4 TX2, bit5 error, bit6 wake-up, bit7 message error. A pulse on `ev_set[i]` makes flag i read 1 after the next edge, whatever the enables are. `rd_sel`=0 reads the flags and `rd_sel`=1 reads the enables.
- R3: `irq_n` is 0 exactly when (flags AND enables) is nonzero. It changes on the same edge as the registers. An enable value of 0x00 keeps `irq_n` at 1.
- R4: A host operation (`op_valid`=1) updates the register picked by `op_sel` (0 = flags, 1 = enables). Each bit set in `op_mask` takes the matching bit of `op_data`, and every other bit keeps its value. The register that is not selected does not change.
- R5: A host clear has no effect on flag i while `cause_hold[i]` is 1.
- R6: If an event and a host clear hit the same flag in the same cycle, the flag ends up at 1.
- R7: `rxfull_n[0]` is the inverse of flag bit0 and `rxfull_n[1]` is the inverse of flag bit1, whatever the enable register holds.
- R8: `irq_code` reports the highest-priority source among the pending enabled ones. The codes, from highest priority to lowest, are: error 001, wake-up 010, TX0 011, TX1 100, TX2 101, RX1 110, RX0 111. The code is 000 when none of these is pending and enabled. The message-error flag has no code of its own.
- R9: With the enables at 0x1F, only the three transmit flags and the two receive flags can pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 8 | One-cycle set pulses, one per source |
| cause_hold | input | 8 | Per-source level that blocks clearing |
| op_valid | input | 1 | Host bit-modify strobe |
| op_sel | input | 1 | Register selected by the operation: 0 flags, 1 enables |
| op_mask | input | 8 | Bits to modify |
| op_data | input | 8 | New values for the masked bits |
| rd_sel | input | 1 | Register to read: 0 flags, 1 enables |
| rd_data | output | 8 | Read data |
| irq_n | output | 1 | Registered active-low interrupt |
| irq_code | output | 3 | Priority code of the pending enabled source |
| rxfull_n | output | 2 | Active-low receive-buffer-full pins |

## Verification
The bench sweeps every enable value against every flag pattern. In each case it checks the interrupt line, the priority code and the buffer-full pins. This exposes a reversed priority order, a code given to the message-error source, and buffer-full pins that wrongly follow the enables.

Three targeted sequences cover the remaining corner cases. A clear in the same cycle as an event would lose the event if a clear wins that conflict. A clear while the hold input is high would drop a request that is still active. A partial mask that touches unmasked bits, or touches the other register, shows up on readback.

// File: rtl/can_irq_flags.sv
module can_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ev_set,
  input  logic [7:0] cause_hold,
  input  logic       op_valid,
  input  logic       op_sel,
  input  logic [7:0] op_mask,
  input  logic [7:0] op_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq_n,
  output logic [2:0] irq_code,
  output logic [1:0] rxfull_n
);
  localparam int B_RX0 = 0, B_RX1 = 1, B_TX0 = 2, B_TX1 = 3, B_TX2 = 4, B_ERR = 5, B_WAK = 6;

  logic [7:0] flags_q, en_q, flags_d, en_d, flags_mod, pend;
  logic       irq_n_q;

  assign flags_mod = (op_valid && !op_sel) ? ((flags_q & ~op_mask) | (op_data & op_mask)) : flags_q;
  assign flags_d   = flags_mod | (flags_q & cause_hold) | ev_set;
  assign en_d      = (op_valid && op_sel) ? ((en_q & ~op_mask) | (op_data & op_mask)) : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= 8'h00;
      en_q    <= 8'h00;
      irq_n_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_n_q <= ~|(flags_d & en_d);
    end
  end

  assign pend = flags_q & en_q;

  always_comb begin
    if      (pend[B_ERR]) irq_code = 3'd1;
    else if (pend[B_WAK]) irq_code = 3'd2;
    else if (pend[B_TX0]) irq_code = 3'd3;
    else if (pend[B_TX1]) irq_code = 3'd4;
    else if (pend[B_TX2]) irq_code = 3'd5;
    else if (pend[B_RX1]) irq_code = 3'd6;
    else if (pend[B_RX0]) irq_code = 3'd7;
    else                  irq_code = 3'd0;
  end

  assign irq_n    = irq_n_q;
  assign rd_data  = rd_sel ? en_q : flags_q;
  assign rxfull_n = ~flags_q[1:0];

  assert_irq_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~|(flags_q & en_q));
  assert_no_irq_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h00) |-> irq_n);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((flags_q & $past(ev_set)) == $past(ev_set)));
  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & cause_hold)) |=> ((flags_q & $past(flags_q & cause_hold)) == $past(flags_q & cause_hold)));
  assert_code_implies_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code != 3'd0) |-> !irq_n);
  assert_enable_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_sel) |=> $stable(en_q));
endmodule

// File: tb/can_irq_flags_tb.sv
module can_irq_flags_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] ev_set = 0, cause_hold = 0, op_mask = 0, op_data = 0;
  logic op_valid = 0, op_sel = 0, rd_sel = 0;
  logic [7:0] rd_data;
  logic irq_n;
  logic [2:0] irq_code;
  logic [1:0] rxfull_n;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_irq_flags u_dut (.clk, .rst_n, .ev_set, .cause_hold, .op_valid, .op_sel,
    .op_mask, .op_data, .rd_sel, .rd_data, .irq_n, .irq_code, .rxfull_n);

  function automatic logic [2:0] exp_code(input logic [7:0] p);
    if (p[5]) return 3'd1;
    if (p[6]) return 3'd2;
    if (p[2]) return 3'd3;
    if (p[3]) return 3'd4;
    if (p[4]) return 3'd5;
    if (p[1]) return 3'd6;
    if (p[0]) return 3'd7;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostop(input logic sel, input logic [7:0] m, input logic [7:0] d);
    @(negedge clk);
    op_valid = 1; op_sel = sel; op_mask = m; op_data = d;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic readreg(input logic sel, output logic [7:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    readreg(0, v); chk("R1 flags", v, 8'h00);
    readreg(1, v); chk("R1 enables", v, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 code", {5'd0, irq_code}, 8'h00);
    chk("R1 rxfull_n", {6'd0, rxfull_n}, 8'h03);

    // R2 each event sets its flag with enables at zero; R3 line stays high
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ev_set = 8'h01 << i;
      @(negedge clk); ev_set = 0;
      readreg(0, v); chk("R2 event set", v, 8'h01 << i);
      chk("R3 disabled irq_n", {7'd0, irq_n}, 8'h01);
      hostop(0, 8'hFF, 8'h00);
    end

    // R4 partial modify, other register untouched
    hostop(1, 8'hFF, 8'hA5);
    hostop(0, 8'hFF, 8'h3C);
    hostop(1, 8'h0F, 8'h50);
    readreg(1, v); chk("R4 enable partial", v, 8'hA0);
    readreg(0, v); chk("R4 flags untouched", v, 8'h3C);
    hostop(0, 8'hF0, 8'h0F);
    readreg(0, v); chk("R4 flags partial", v, 8'h0C);
    readreg(1, v); chk("R4 enables untouched", v, 8'hA0);

    // R5 hold blocks clearing
    hostop(0, 8'hFF, 8'h01);
    cause_hold = 8'h01;
    hostop(0, 8'h01, 8'h00);
    readreg(0, v); chk("R5 held flag", v, 8'h01);
    cause_hold = 8'h00;
    hostop(0, 8'h01, 8'h00);
    readreg(0, v); chk("R5 release clears", v, 8'h00);

    // R6 set beats clear in the same cycle
    hostop(0, 8'hFF, 8'h08);
    @(negedge clk);
    op_valid = 1; op_sel = 0; op_mask = 8'h08; op_data = 8'h00; ev_set = 8'h08;
    @(negedge clk);
    op_valid = 0; ev_set = 0;
    readreg(0, v); chk("R6 set wins", v, 8'h08);

    // R9 enable 0x1F
    hostop(1, 8'hFF, 8'h1F);
    hostop(0, 8'hFF, 8'hE0);
    chk("R9 upper flags masked", {7'd0, irq_n}, 8'h01);
    hostop(0, 8'hFF, 8'h10);
    chk("R9 TX2 passes", {7'd0, irq_n}, 8'h00);

    // R3 R7 R8 sweep over all enable and flag values
    for (int e = 0; e < 256; e++) begin
      hostop(1, 8'hFF, 8'(e));
      for (int f = 0; f < 256; f++) begin
        hostop(0, 8'hFF, 8'(f));
        chk("R3 irq_n", {7'd0, irq_n}, {7'd0, ((8'(f) & 8'(e)) == 8'h00)});
        chk("R8 code", {5'd0, irq_code}, {5'd0, exp_code(8'(f) & 8'(e))});
        chk("R7 rxfull_n", {6'd0, rxfull_n}, {6'd0, ~f[1:0]});
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule